// File: doc/BRIEF.md
# Private Core Countdown Timer

A 32-bit down-counter with an 8-bit prescaler, controlled through four word registers in a 32-byte window: reload value, live count, control, and event status. Once armed, the count drops by one every (prescaler + 1) clocks. When it reaches zero the status flag is set. The counter then either halts at zero (single-shot) or refills from the reload register on the next prescaled step (auto-reload). A single level interrupt follows the status flag, gated by an enable bit in the control word. Software clears the flag by writing a one to it.

Arming follows a small two-state machine, `ST_IDLE` and `ST_RUN`. The transitions are:
- **START**: a register write that leaves the timer enabled with work to do moves it to `ST_RUN`.
- **STOP**: a write that disables the timer or zeroes it silently moves it to `ST_IDLE`.
- **EXPIRE**: a single-shot expiry moves it to `ST_IDLE`.
- **TERMINAL**: an auto-reload expiry with a zero reload value and a zero prescaler moves it to `ST_IDLE`.
- **RELOAD**: an auto-reload refill keeps the timer in `ST_RUN`.

Every write to the reload, count or control register restarts the prescaler phase.

Top module: `cdt_timer`

## Requirements
- R1: After reset the reload, count, control and status registers read zero, the timer is idle and `irq` is low.
- R2: Word offsets are 0x0 reload, 0x4 count, 0x8 control and 0xC status. Control bit 0 is enable, bit 1 is auto-reload, bit 2 is interrupt enable, and bits 15:8 are the prescaler. All other control bits read zero. Read data appears on `rdata` one clock after `rd_en`.
- R3: Reads of offsets 0x10 to 0x1F, or of unaligned addresses, return zero. Writes to them change no register.
- R4: While running, the count changes only on the clock edge that ends each span of (prescaler + 1) clocks, measured from the arming write.
- R5: In single-shot mode, the step from one to zero sets status, leaves the count at zero and goes idle.
- R6: In auto-reload mode, the step after reaching zero loads the count from the reload register, so the count repeats with a period of reload + 1 steps.
- R7: `irq` is high exactly when the status flag and control bit 2 are both set.
- R8: A status write with bit 0 set clears the flag. A write with bit 0 clear leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R9: A reload write also sets the count. It arms the timer when enabled, unless the prescaler and the written value are both zero; in that case the timer stops and sets no status.
- R10: A count write of zero while enabled with a zero prescaler stops the timer without status, in single-shot mode or in auto-reload mode with a zero reload. A nonzero count write while enabled restarts counting from that value.
- R11: Auto-reload with a zero reload value sets status on every prescaled step when the prescaler is nonzero. With a zero prescaler, it sets status once and goes idle.
- R12: A control write recomputes arming from the new word. If the new word is enabled in auto-reload mode and the count is zero, the count is first loaded from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the silent-stop paths: zero reload and zero count writes with a zero prescaler. A design that treated these as ordinary expiries would raise a spurious status flag. Auto-reload with a zero reload value is driven both ways. A wrong design would either keep firing when the prescaler is zero or go quiet when it is nonzero. Random prescaler, reload and wait lengths probe the step timing and the refill step, where an off-by-one in the prescaler phase or in the refill would show as a wrong count. Write-one-to-clear is tested with a zero bit and with foreign bits, which a design decoding the whole word would mishandle.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int PRE_W   = 8;
    localparam int PRE_LSB = 8;
    localparam int BIT_EN  = 0;
    localparam int BIT_REL = 1;
    localparam int BIT_IE  = 2;

    localparam int REG_RELOAD = 0;
    localparam int REG_COUNT  = 1;
    localparam int REG_CTRL   = 2;
    localparam int REG_STATUS = 3;
    localparam int REG_NUM    = 4;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             ie;
        logic             reload;
        logic             en;
    } ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [PW-1:0] limit,
    output logic          tick
);

    logic [PW-1:0] phase_q;

    assign tick = run && !restart && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !run || (phase_q == limit)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdt_engine.sv
module cdt_engine
    import cdt_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld_wr,
    input  logic          cnt_wr,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wval,
    input  logic          cur_en,
    input  logic          cur_rel,
    input  logic [PW-1:0] cur_presc,
    input  logic          new_en,
    input  logic          new_rel,
    input  logic [PW-1:0] new_presc,
    input  logic [DW-1:0] reload_val,
    output logic [DW-1:0] count_o,
    output logic          running_o,
    output logic          expire_o
);

    localparam logic [DW-1:0] ONE = DW'(1);

    run_state_e    state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;
    logic          terminal;
    logic          wzero;
    logic          cur_p0;

    assign cur_p0   = (cur_presc == '0);
    assign wzero    = (wval == '0);
    assign terminal = !cur_rel || ((reload_val == '0) && cur_p0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (tick) begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - ONE;
                        if (cnt_q == ONE) begin
                            expire_o = 1'b1;
                            if (terminal) state_d = ST_IDLE;
                        end
                    end else begin
                        expire_o = !cur_rel || (reload_val == '0);
                        if (cur_rel) cnt_d = reload_val;
                        if (terminal) state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (ld_wr) begin
            cnt_d   = wval;
            state_d = (cur_en && (!cur_p0 || !wzero)) ? ST_RUN : ST_IDLE;
        end else if (cnt_wr) begin
            cnt_d   = (cur_en && cur_rel && cur_p0 && wzero) ? reload_val : wval;
            state_d = (cur_en && (!cur_p0 || (cnt_d != '0))) ? ST_RUN : ST_IDLE;
        end else if (ctl_wr) begin
            cnt_d   = (new_en && new_rel && (cnt_q == '0)) ? reload_val : cnt_q;
            state_d = (new_en && ((new_presc != '0) || (cnt_d != '0))) ? ST_RUN : ST_IDLE;
        end
    end

    assign count_o   = cnt_q;
    assign running_o = (state_q == ST_RUN);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic              aligned;
    logic              ld_wr, cnt_wr, ctl_wr, stat_wr;
    logic              restart_w;
    logic              tick_w;
    logic              run_w;
    logic              evt_w;
    logic [DATA_W-1:0] count_w;
    logic [DATA_W-1:0] load_q;
    logic              status_q;
    ctrl_t             ctrl_q, ctrl_new;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign ld_wr   = wr_en && aligned && (widx == IDX_W'(REG_RELOAD));
    assign cnt_wr  = wr_en && aligned && (widx == IDX_W'(REG_COUNT));
    assign ctl_wr  = wr_en && aligned && (widx == IDX_W'(REG_CTRL));
    assign stat_wr = wr_en && aligned && (widx == IDX_W'(REG_STATUS));
    assign restart_w = ld_wr || cnt_wr || ctl_wr;

    assign ctrl_new.presc  = wdata[PRE_LSB +: PRE_W];
    assign ctrl_new.ie     = wdata[BIT_IE];
    assign ctrl_new.reload = wdata[BIT_REL];
    assign ctrl_new.en     = wdata[BIT_EN];

    cdt_prescaler #(.PW(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (restart_w),
        .limit   (ctrl_q.presc),
        .tick    (tick_w)
    );

    cdt_engine #(.DW(DATA_W), .PW(PRE_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .ld_wr      (ld_wr),
        .cnt_wr     (cnt_wr),
        .ctl_wr     (ctl_wr),
        .wval       (wdata),
        .cur_en     (ctrl_q.en),
        .cur_rel    (ctrl_q.reload),
        .cur_presc  (ctrl_q.presc),
        .new_en     (ctrl_new.en),
        .new_rel    (ctrl_new.reload),
        .new_presc  (ctrl_new.presc),
        .reload_val (load_q),
        .count_o    (count_w),
        .running_o  (run_w),
        .expire_o   (evt_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= '0;
            ctrl_q   <= '0;
            status_q <= 1'b0;
        end else begin
            if (ld_wr)  load_q <= wdata;
            if (ctl_wr) ctrl_q <= ctrl_new;
            if (evt_w) begin
                status_q <= 1'b1;
            end else if (stat_wr && wdata[0]) begin
                status_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (aligned) begin
            case (widx)
                IDX_W'(REG_RELOAD): rd_word = load_q;
                IDX_W'(REG_COUNT):  rd_word = count_w;
                IDX_W'(REG_CTRL): begin
                    rd_word[PRE_LSB +: PRE_W] = ctrl_q.presc;
                    rd_word[BIT_IE]           = ctrl_q.ie;
                    rd_word[BIT_REL]          = ctrl_q.reload;
                    rd_word[BIT_EN]           = ctrl_q.en;
                end
                IDX_W'(REG_STATUS): rd_word[0] = status_q;
                default:            rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_word;
        end
    end

    assign rdata = rdata_q;
    assign irq   = status_q && ctrl_q.ie;

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              status,
    input ctrl_t             ctrl,
    input logic [DATA_W-1:0] load,
    input logic [DATA_W-1:0] count,
    input logic              running,
    input logic              tick,
    input logic              restart
);

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ctrl.reload && (count == DATA_W'(1)) && tick)
        |=> ((count == '0) && !running && status));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(12)) && wdata[0] && !tick) |=> !status);

    // R3
    hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr[ADDR_W-1:2] >= (ADDR_W-2)'(REG_NUM)))
        |=> ($stable(ctrl) && $stable(load)));

    // R9
    zero_reload_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == '0) && ctrl.en && (ctrl.presc == '0) && (wdata == '0))
        |=> (!running && $stable(status)));

endmodule

bind cdt_timer cdt_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .status  (status_q),
    .ctrl    (ctrl_q),
    .load    (load_q),
    .count   (count_w),
    .running (run_w),
    .tick    (tick_w),
    .restart (restart_w)
);

// File: tb/sim_cdt_timer.sv
module sim_cdt_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_RLD = 5'h00;
    localparam logic [4:0] A_CNT = 5'h04;
    localparam logic [4:0] A_CTL = 5'h08;
    localparam logic [4:0] A_STA = 5'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdt_timer u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int unsigned exp_count(int unsigned l, int unsigned p,
                                              int unsigned w, bit per);
        int unsigned t = w / (p + 1);
        if (per) return l - (t % (l + 1));
        return (t >= l) ? 0 : l - t;
    endfunction

    function automatic bit exp_fired(int unsigned l, int unsigned p, int unsigned w);
        return (w / (p + 1)) >= l;
    endfunction

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_RLD, v); check("R1 reload", v, 0);
        rd(A_CNT, v); check("R1 count", v, 0);
        rd(A_CTL, v); check("R1 control", v, 0);
        rd(A_STA, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 control fields
        wr(A_CTL, 32'hFFFF_FFF8);
        rd(A_CTL, v); check("R2 control mask", v, 32'h0000_FF00);
        wr(A_CTL, 32'h0000_AB06);
        rd(A_CTL, v); check("R2 control fields", v, 32'h0000_AB06);
        wr(A_CTL, 32'h0);

        // R3 undefined offsets
        wr(A_RLD, 32'h1234);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h14, v); check("R3 hole read", v, 0);
        rd(A_RLD, v); check("R3 reload kept", v, 32'h1234);
        rd(A_CTL, v); check("R3 control kept", v, 0);
        rd(A_CNT, v); check("R3 count kept", v, 32'h1234);

        // R9 zero reload write stops silently
        wr(A_CTL, 32'h1);
        wait_n(3);
        wr(A_RLD, 32'h0);
        wait_n(5);
        rd(A_CNT, v); check("R9 count zero", v, 0);
        rd(A_STA, v); check("R9 no status", v, 0);
        wr(A_RLD, 32'd50);
        wait_n(4);
        rd(A_CNT, v); check("R9 restart", v, 46);

        // R10 zero count write stops silently
        wr(A_CNT, 32'h0);
        wait_n(5);
        rd(A_STA, v); check("R10 no status", v, 0);
        rd(A_CNT, v); check("R10 count zero", v, 0);
        wr(A_CNT, 32'd9);
        wait_n(2);
        rd(A_CNT, v); check("R10 restart", v, 7);
        wait_n(20);
        rd(A_CNT, v); check("R5 held at zero", v, 0);
        rd(A_STA, v); check("R5 status set", v, 1);
        check("R7 irq gated off", {31'b0, irq}, 0);
        wr(A_CTL, 32'h5);
        check("R7 irq on", {31'b0, irq}, 1);

        // R8 write one to clear
        wr(A_STA, 32'h0);
        rd(A_STA, v); check("R8 zero write", v, 1);
        wr(A_STA, 32'h2);
        rd(A_STA, v); check("R8 other bit", v, 1);
        wr(A_STA, 32'h1);
        rd(A_STA, v); check("R8 cleared", v, 0);
        check("R8 irq low", {31'b0, irq}, 0);

        // R11 periodic, zero reload, zero prescaler
        wr(A_CTL, 32'h2);
        wr(A_RLD, 32'h0);
        wr(A_CNT, 32'd3);
        wr(A_CTL, 32'h3);
        wait_n(10);
        rd(A_CNT, v); check("R11 count zero", v, 0);
        rd(A_STA, v); check("R11 one event", v, 1);
        wr(A_STA, 32'h1);
        wait_n(10);
        rd(A_STA, v); check("R11 no repeat", v, 0);

        // R11 periodic, zero reload, nonzero prescaler
        wr(A_CTL, 32'h202);
        wr(A_CTL, 32'h203);
        wait_n(5);
        rd(A_STA, v); check("R11 recurring first", v, 1);
        wr(A_STA, 32'h1);
        wait_n(4);
        rd(A_STA, v); check("R11 recurring again", v, 1);
        rd(A_CNT, v); check("R11 count stays zero", v, 0);

        // R12 control write reloads zero count
        wr(A_CTL, 32'h2);
        wr(A_STA, 32'h1);
        wr(A_RLD, 32'd7);
        wr(A_CNT, 32'h0);
        wr(A_CTL, 32'h3);
        rd(A_CNT, v); check("R12 reloaded", v, 7);
        wait_n(2);
        rd(A_CNT, v); check("R4 step timing", v, 4);

        // random sweep (R4 R5 R6 R7)
        wr(A_CTL, 32'h0);
        wr(A_STA, 32'h1);
        for (int i = 0; i < 24; i++) begin
            int unsigned p = $urandom_range(0, 3);
            int unsigned l = $urandom_range(1, 12);
            int unsigned per = $urandom_range(0, 1);
            int unsigned w = $urandom_range(0, 70);
            logic [31:0] cw = {16'h0, p[7:0], 5'h0, 1'b1, per[0], 1'b0};
            wr(A_CTL, cw);
            wr(A_STA, 32'h1);
            wr(A_RLD, l);
            wr(A_CTL, cw | 32'h1);
            wait_n(w);
            rd(A_CNT, v);
            check(per[0] ? "R4 R6 periodic count" : "R4 R5 oneshot count",
                  v, exp_count(l, p, w, per[0]));
            check("R7 irq", {31'b0, irq}, {31'b0, exp_fired(l, p, w + 1)});
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule